// File: doc/BRIEF.md
# Interrupt Master Enable and Halt Controller

This block holds the processor's global interrupt enable bit and its halted state. The execute stage reports each completed instruction with a boundary pulse. The pulse comes with one-cycle strobes that say whether that instruction was a disable, an enable, a return-from-interrupt or a halt. The block also watches the 5-bit interrupt-enable and interrupt-flag registers. An interrupt is pending when their bitwise AND is non-zero.

Outputs go to the fetch and dispatch logic. When the block grants an interrupt, it raises a dispatch request with a handler address. In the same cycle it gives a one-hot mask of the flag bit to clear. The enable instruction takes effect one instruction late, and return-from-interrupt takes effect at once. Halt exits in one of three ways, depending on the enable bit and on whether an interrupt is already pending. In one of these ways the block asks fetch not to advance the program counter, so the byte after the halt is read twice.

Top module: `ime_halt_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `imeOut`, `haltedOut`, `skipPcInc` and `dispatchReq` are all 0.
- R2: An enable strobe at a boundary leaves `imeOut` at 0 through the instruction that follows. `imeOut` becomes 1 at the clock edge that ends that following instruction's boundary cycle.
- R3: A disable strobe at a boundary clears `imeOut` at that edge. No dispatch is requested in that boundary cycle, even if an interrupt is pending.
- R4: A disable strobe at the boundary right after an enable cancels the armed enable, so `imeOut` stays 0 afterwards.
- R5: A return-from-interrupt strobe at a boundary sets `imeOut` at that same edge.
- R6: When the request is raised, the granted source is the pending bit with the lowest index. `dispatchVec` is 0x40 + 8 × index. `flagClear` is the one-hot mask of that bit (bit i = source i). `flagClear` is 0 whenever no request is raised.
- R7: `dispatchReq` is raised only when `imeOut` is 1, an interrupt is pending, and the cycle is a boundary (`instrDone` high or `haltedOut` high).
- R8: A dispatch clears `imeOut` at the edge ending the request cycle.
- R9: A halt strobe with `imeOut` at 1 and nothing pending sets `haltedOut`. The block then stays halted until an interrupt becomes pending, requests the dispatch in that cycle, and leaves the halted state at the same edge. If an interrupt is already pending when the halt strobe arrives with `imeOut` at 1, the block dispatches at once and does not halt.
- R10: A halt strobe with `imeOut` at 0 and nothing pending sets `haltedOut`. When an interrupt becomes pending, `haltedOut` drops at the next edge and no dispatch is requested.
- R11: A halt strobe with `imeOut` at 0 and an interrupt pending does not halt. Instead `skipPcInc` rises at that edge and stays high until the edge ending the next boundary cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrDone | input | 1 | Instruction boundary pulse |
| diStrobe | input | 1 | Completing instruction disables interrupts |
| eiStrobe | input | 1 | Completing instruction enables interrupts (delayed) |
| retiStrobe | input | 1 | Completing instruction is return-from-interrupt |
| haltStrobe | input | 1 | Completing instruction is halt |
| intEnable | input | 5 | Interrupt-enable register |
| intFlag | input | 5 | Interrupt-flag register |
| imeOut | output | 1 | Interrupt master enable |
| haltedOut | output | 1 | Processor halted |
| dispatchReq | output | 1 | Interrupt dispatch request |
| dispatchVec | output | 16 | Handler address of the granted source |
| flagClear | output | 5 | One-hot flag bit to clear on dispatch |
| skipPcInc | output | 1 | Next opcode fetch must not increment PC |

## Verification
If the enable bit were armed or disarmed wrongly, the effect would show at a port one boundary late at most: `imeOut` would change an instruction early or late, or a dispatch would appear or go missing at the next pending boundary. A wrong halted state shows at `haltedOut` in the cycle after the halt strobe, and a wrong wake shows in the cycle after the flag rises. A lost skip state shows at `skipPcInc` in the cycle after the halt. A wrong priority shows at once in `dispatchVec` and `flagClear`.

// File: rtl/imeh_pkg.sv
package imeh_pkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic dispatch;  // grant the highest-priority pending source this cycle
  } ctlStrobe_t;
endpackage

// File: rtl/irq_select.sv
module irq_select
  import imeh_pkg::*;
#(
  parameter int NUM_SRC = 5,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'h0040,
  parameter int VEC_STRIDE = 8
) (
  input  logic [NUM_SRC-1:0] intEnable,
  input  logic [NUM_SRC-1:0] intFlag,
  input  ctlStrobe_t         ctl,
  output logic               anyPending,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic [NUM_SRC-1:0] flagClear
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC:0]   seenLower;
  logic [NUM_SRC-1:0] grant;
  logic [IDX_W-1:0]   grantIdx;

  assign pend = intEnable & intFlag;
  assign seenLower[0] = 1'b0;

  // Lowest index wins: each stage passes on whether a lower bit is pending
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
    assign grant[i] = pend[i] & ~seenLower[i];
    assign seenLower[i+1] = seenLower[i] | pend[i];
  end

  assign anyPending = seenLower[NUM_SRC];

  always_comb begin
    grantIdx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grant[i]) grantIdx = IDX_W'(i);
    end
  end

  assign vecAddr = VEC_BASE + ADDR_W'(grantIdx) * ADDR_W'(VEC_STRIDE);
  assign flagClear = ctl.dispatch ? grant : '0;
endmodule

// File: rtl/ime_halt_ctrl.sv
module ime_halt_ctrl
  import imeh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instrDone,
  input  logic       diStrobe,
  input  logic       eiStrobe,
  input  logic       retiStrobe,
  input  logic       haltStrobe,
  input  logic       anyPending,
  output logic       imeQ,
  output logic       haltedQ,
  output logic       skipQ,
  output ctlStrobe_t ctl
);
  logic eiArmedQ;
  logic evt;
  logic boundary;
  logic dispatch;
  logic imeD, eiArmedD, haltedD, skipD;

  always_comb begin
    // strobes count only for an instruction that completes while running
    evt = instrDone & ~haltedQ;
    boundary = instrDone | haltedQ;
    dispatch = imeQ & anyPending & boundary & ~(evt & diStrobe);

    imeD = imeQ;
    eiArmedD = eiArmedQ;
    if (dispatch) begin
      imeD = 1'b0;
      eiArmedD = 1'b0;
    end else if (evt) begin
      if (diStrobe) begin
        imeD = 1'b0;
        eiArmedD = 1'b0;
      end else begin
        if (retiStrobe || eiArmedQ) imeD = 1'b1;
        eiArmedD = eiStrobe;
      end
    end

    haltedD = haltedQ;
    if (haltedQ) begin
      if (anyPending) haltedD = 1'b0;
    end else if (evt && haltStrobe && !anyPending) begin
      haltedD = 1'b1;
    end

    skipD = skipQ;
    if (evt) skipD = haltStrobe & ~imeQ & anyPending;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      imeQ <= 1'b0;
      eiArmedQ <= 1'b0;
      haltedQ <= 1'b0;
      skipQ <= 1'b0;
    end else begin
      imeQ <= imeD;
      eiArmedQ <= eiArmedD;
      haltedQ <= haltedD;
      skipQ <= skipD;
    end
  end

  assign ctl.dispatch = dispatch;
endmodule

// File: rtl/ime_halt_unit.sv
module ime_halt_unit
  import imeh_pkg::*;
#(
  parameter int NUM_SRC = 5,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'h0040,
  parameter int VEC_STRIDE = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrDone,
  input  logic               diStrobe,
  input  logic               eiStrobe,
  input  logic               retiStrobe,
  input  logic               haltStrobe,
  input  logic [NUM_SRC-1:0] intEnable,
  input  logic [NUM_SRC-1:0] intFlag,
  output logic               imeOut,
  output logic               haltedOut,
  output logic               dispatchReq,
  output logic [ADDR_W-1:0]  dispatchVec,
  output logic [NUM_SRC-1:0] flagClear,
  output logic               skipPcInc
);
  ctlStrobe_t ctl;
  logic anyPending;

  ime_halt_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .instrDone  (instrDone),
    .diStrobe   (diStrobe),
    .eiStrobe   (eiStrobe),
    .retiStrobe (retiStrobe),
    .haltStrobe (haltStrobe),
    .anyPending (anyPending),
    .imeQ       (imeOut),
    .haltedQ    (haltedOut),
    .skipQ      (skipPcInc),
    .ctl        (ctl)
  );

  irq_select #(
    .NUM_SRC    (NUM_SRC),
    .ADDR_W     (ADDR_W),
    .VEC_BASE   (VEC_BASE),
    .VEC_STRIDE (VEC_STRIDE)
  ) u_sel (
    .intEnable  (intEnable),
    .intFlag    (intFlag),
    .ctl        (ctl),
    .anyPending (anyPending),
    .vecAddr    (dispatchVec),
    .flagClear  (flagClear)
  );

  assign dispatchReq = ctl.dispatch;
endmodule

// File: rtl/ime_halt_chk.sv
module ime_halt_chk #(
  parameter int NUM_SRC = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               instrDone,
  input logic               diStrobe,
  input logic               retiStrobe,
  input logic               haltStrobe,
  input logic [NUM_SRC-1:0] intEnable,
  input logic [NUM_SRC-1:0] intFlag,
  input logic               imeOut,
  input logic               haltedOut,
  input logic               dispatchReq,
  input logic [NUM_SRC-1:0] flagClear,
  input logic               skipPcInc
);
  logic pendNow;
  assign pendNow = |(intEnable & intFlag);

  // R7
  dispatch_needs_ime_chk: assert property (@(posedge clk) disable iff (!rstN)
    dispatchReq |-> (imeOut && pendNow));
  // R7
  dispatch_at_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    dispatchReq |-> (instrDone || haltedOut));
  // R8
  dispatch_clears_ime_chk: assert property (@(posedge clk) disable iff (!rstN)
    dispatchReq |=> !imeOut);
  // R6
  clear_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    dispatchReq |-> ($countones(flagClear) == 1 && (flagClear & intEnable & intFlag) == flagClear));
  // R6
  clear_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dispatchReq |-> (flagClear == '0));
  // R3
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrDone && diStrobe && !haltedOut) |=> !imeOut);
  // R5
  reti_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrDone && retiStrobe && !haltedOut && !dispatchReq) |=> imeOut);
  // R10
  halt_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (haltedOut && !pendNow) |=> haltedOut);
  // R9
  halt_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!haltedOut && !(instrDone && haltStrobe)) |=> !haltedOut);
  // R11
  skip_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (skipPcInc && !instrDone) |=> skipPcInc);
endmodule

bind ime_halt_unit ime_halt_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .instrDone   (instrDone),
  .diStrobe    (diStrobe),
  .retiStrobe  (retiStrobe),
  .haltStrobe  (haltStrobe),
  .intEnable   (intEnable),
  .intFlag     (intFlag),
  .imeOut      (imeOut),
  .haltedOut   (haltedOut),
  .dispatchReq (dispatchReq),
  .flagClear   (flagClear),
  .skipPcInc   (skipPcInc)
);

// File: tb/sim_ime_halt_unit.sv
module sim_ime_halt_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instrDone = 1'b0, diStrobe = 1'b0, eiStrobe = 1'b0, retiStrobe = 1'b0, haltStrobe = 1'b0;
  logic [4:0] intEnable = 5'h1F, intFlag = 5'h00;
  logic imeOut, haltedOut, dispatchReq, skipPcInc;
  logic [15:0] dispatchVec;
  logic [4:0] flagClear;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic ime;
    logic halted;
    logic skip;
    logic disp;
    logic [4:0] clr;
    logic [15:0] vec;
  } obs_t;

  obs_t expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;  // 50 MHz

  ime_halt_unit u0 (
    .clk(clk), .rstN(rstN), .instrDone(instrDone), .diStrobe(diStrobe),
    .eiStrobe(eiStrobe), .retiStrobe(retiStrobe), .haltStrobe(haltStrobe),
    .intEnable(intEnable), .intFlag(intFlag), .imeOut(imeOut),
    .haltedOut(haltedOut), .dispatchReq(dispatchReq), .dispatchVec(dispatchVec),
    .flagClear(flagClear), .skipPcInc(skipPcInc)
  );

  function automatic obs_t actual();
    obs_t a;
    a.ime = imeOut; a.halted = haltedOut; a.skip = skipPcInc;
    a.disp = dispatchReq; a.clr = flagClear; a.vec = dispatchVec;
    return a;
  endfunction

  // Driver: one cycle of stimulus plus the outputs expected in that cycle
  task automatic step(input logic d, input logic di, input logic ei, input logic rt,
                      input logic hl, input logic [4:0] ie, input logic [4:0] fl,
                      input logic eIme, input logic eHalt, input logic eSkip,
                      input logic eDisp, input int eIdx, input string tag);
    obs_t e;
    @(posedge clk); #1;
    instrDone = d; diStrobe = di; eiStrobe = ei; retiStrobe = rt; haltStrobe = hl;
    intEnable = ie; intFlag = fl;
    e.ime = eIme; e.halted = eHalt; e.skip = eSkip; e.disp = eDisp;
    e.clr = eDisp ? (5'b1 << eIdx) : 5'b0;
    e.vec = 16'h0040 + 16'(eIdx) * 16'd8;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  // Monitor: compare away from the active edge
  always @(negedge clk) begin
    if (rstN && expQ.size() > 0) begin
      obs_t e, a;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      a = actual();
      if (!e.disp) a.vec = e.vec;
      checks++;
      if (a != e) begin
        errors++;
        $display("FAIL %s: ime/halt/skip/disp/clr/vec actual=%b/%b/%b/%b/%b/%h expected=%b/%b/%b/%b/%b/%h",
                 t, a.ime, a.halted, a.skip, a.disp, a.clr, a.vec,
                 e.ime, e.halted, e.skip, e.disp, e.clr, e.vec);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    // R1 reset state, sampled while reset is held with an interrupt pending
    intFlag = 5'h1F;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({imeOut, haltedOut, skipPcInc, dispatchReq} != 4'b0) begin
      errors++;
      $display("FAIL R1: actual=%b expected=0000", {imeOut, haltedOut, skipPcInc, dispatchReq});
    end
    @(posedge clk); #1;
    rstN = 1'b1; intFlag = 5'h00;
    //   d di ei rt hl ie     fl      ime hlt skp dsp idx
    step(0, 0, 0, 0, 0, 5'h1F, 5'h00, 0, 0, 0, 0, 0, "R1");
    // R2 delayed enable
    step(1, 0, 1, 0, 0, 5'h1F, 5'h00, 0, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 0, 0, 5'h1F, 5'h00, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 5'h1F, 5'h00, 1, 0, 0, 0, 0, "R2");
    // R3 disable with a pending source: no dispatch, IME drops
    step(1, 1, 0, 0, 0, 5'h1F, 5'h01, 1, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 0, 5'h1F, 5'h00, 0, 0, 0, 0, 0, "R3");
    // R4 enable then disable at once
    step(1, 0, 1, 0, 0, 5'h1F, 5'h00, 0, 0, 0, 0, 0, "R4");
    step(1, 1, 0, 0, 0, 5'h1F, 5'h00, 0, 0, 0, 0, 0, "R4");
    step(1, 0, 0, 0, 0, 5'h1F, 5'h00, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 5'h1F, 5'h00, 0, 0, 0, 0, 0, "R4");
    // R5 return-from-interrupt takes effect at once
    step(1, 0, 0, 1, 0, 5'h1F, 5'h00, 0, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 5'h1F, 5'h00, 1, 0, 0, 0, 0, "R5");
    // R7 not at a boundary; R6 priority with bits 2 and 4 pending
    step(0, 0, 0, 0, 0, 5'h1C, 5'h16, 1, 0, 0, 0, 0, "R7");
    step(1, 0, 0, 0, 0, 5'h1C, 5'h16, 1, 0, 0, 1, 2, "R6");
    step(1, 0, 0, 0, 0, 5'h1C, 5'h12, 0, 0, 0, 0, 0, "R8");
    // R9 halt with IME set, nothing pending
    step(1, 0, 0, 1, 0, 5'h1F, 5'h00, 0, 0, 0, 0, 0, "R5");
    step(1, 0, 0, 0, 1, 5'h1F, 5'h00, 1, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 5'h1F, 5'h00, 1, 1, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 5'h1F, 5'h01, 1, 1, 0, 1, 0, "R9");
    step(0, 0, 0, 0, 0, 5'h1F, 5'h00, 0, 0, 0, 0, 0, "R9");
    // R10 halt with IME clear, nothing pending
    step(1, 0, 0, 0, 1, 5'h1F, 5'h00, 0, 0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 5'h1F, 5'h00, 0, 1, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 5'h1F, 5'h08, 0, 1, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 5'h1F, 5'h08, 0, 0, 0, 0, 0, "R10");
    // R11 halt with IME clear and a pending source
    step(1, 0, 0, 0, 1, 5'h1F, 5'h08, 0, 0, 0, 0, 0, "R11");
    step(0, 0, 0, 0, 0, 5'h1F, 5'h08, 0, 0, 1, 0, 0, "R11");
    step(1, 0, 0, 0, 0, 5'h1F, 5'h08, 0, 0, 1, 0, 0, "R11");
    step(0, 0, 0, 0, 0, 5'h1F, 5'h00, 0, 0, 0, 0, 0, "R11");
    // R6 highest index source alone
    step(1, 0, 0, 1, 0, 5'h1F, 5'h00, 0, 0, 0, 0, 0, "R5");
    step(1, 0, 0, 0, 0, 5'h1F, 5'h10, 1, 0, 0, 1, 4, "R6");
    step(0, 0, 0, 0, 0, 5'h1F, 5'h00, 0, 0, 0, 0, 0, "R8");
    // R9 halt with IME set and already pending: dispatch, no halt
    step(1, 0, 0, 1, 0, 5'h1F, 5'h00, 0, 0, 0, 0, 0, "R5");
    step(1, 0, 0, 0, 1, 5'h1F, 5'h02, 1, 0, 0, 1, 1, "R9");
    step(0, 0, 0, 0, 0, 5'h1F, 5'h00, 0, 0, 0, 0, 0, "R9");
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule